// File: doc/BRIEF.md
# Daisy-Chain ADC Serial Port

This block is the serial side of one converter that can be cascaded with copies of itself: the SDO of each copy feeds the SDI of the next, and a host clocks the whole chain like one long shift register. The pins `cnvst`, `sdi` and `sclk` are levels already synchronised to the system clock `clk`; their edges are found by comparing each level with its value one clock earlier. A separate converter model supplies a result word together with a one-cycle done strobe.

A rising edge on `cnvst` starts a conversion and latches two settings from pin levels: the port runs as a chain member when `sdi` is low at that edge, and it emits a busy bit ahead of its data when `sclk` is high at that edge. When the done strobe arrives, the result is loaded into a shift register and its MSB, or the busy bit, appears on `sdo`. Falling `sclk` edges move the word out MSB first, and the upstream stream enters at the bottom. The busy bit rises only once the device's own result is loaded and the upstream device shows its busy bit, so the busy bit reaching the host means that every device in the chain has finished. Parameter `IS_HEAD` marks the first device, which needs no upstream busy.

Top module: `chain_adc_port`

## Requirements
- R1: A `cnvst` rise with `sdi` low selects chain mode, and `sdo_en` is then 1 from the next cycle on. A rise with `sdi` high leaves `sdo_en` at 0 while `cnvst` stays high, and `sdo` stays 0 even after a result is loaded.
- R2: The `sclk` level at the `cnvst` rise selects the busy option (1 = busy bit first). With the option on, the first `sdo` value after the result is loaded is the busy bit (1), whatever the data MSB is.
- R3: While `cnvst` and `sdi` are both 0, `sdo` is 0 and `sdo_en` is 1 in the same cycle.
- R4: From the cycle after a `cnvst` rise until the done strobe, a chain-mode port outputs 0 on `sdo`.
- R5: Without the busy option, the cycle after the done strobe `sdo` shows bit 15 of the loaded result.
- R6: Without the busy option, each `sclk` fall shifts the register up by one bit and takes `sdi` into bit 0. For N chained devices, 16×N falls read every word, the word of the device nearest the host first, each MSB first.
- R7: With the busy option, the busy bit is set only when the own result is loaded and the upstream `sdi` is 1 in the same cycle or later. The head device needs only its own result. A port that loads in the same cycle that its upstream busy appears sets its busy bit one cycle after that.
- R8: With the busy option, the first `sclk` fall drops the busy bit and exposes bit 15 without shifting. Each later fall shifts as in R6, so N devices need 1+16×N falls.
- R9: `sclk` falls during a conversion, including one in the same cycle as the done strobe, change nothing. A done strobe outside a conversion is ignored.
- R10: During and right after reset, `sdo` is 0. With `cnvst` high, `sdo_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnvst | input | 1 | Conversion start level; a rise starts a conversion |
| sdi | input | 1 | Serial input from upstream SDO, also the mode select |
| sclk | input | 1 | Serial clock level; falls shift the register |
| conv_done | input | 1 | One-cycle strobe from the converter model |
| conv_data | input | DATA_W | Result word valid with `conv_done` |
| sdo | output | 1 | Serial output |
| sdo_en | output | 1 | Output driver enable |

## Verification
Two events can land in the same cycle. The first pair is a device's own done strobe and the arrival of the upstream busy bit. The bench runs two chained ports with the upstream done strobe first, the downstream one first, or both together, and checks how many cycles later the downstream `sdo` rises against R7. The second pair is an `sclk` fall and the done strobe. The bench drives them on the same edge and then requires the complete 32- or 33-bit readback to match a model built from the random words, so a fall that slipped in would show up as a skewed stream.

// File: rtl/chain_adc_pkg.sv
package chain_adc_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CONV  = 2'd1,
        PH_READY = 2'd2
    } phase_t;

    typedef struct packed {
        logic chain;
        logic busy;
    } port_cfg_t;

    // Bit presented on the serial output while a busy bit is pending or not.
    function automatic logic pick_out(input logic pend, input logic busy_bit, input logic msb);
        return pend ? busy_bit : msb;
    endfunction

endpackage

// File: rtl/chain_edge_sense.sv
module chain_edge_sense #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    generate
        for (genvar g = 0; g < N; g++) begin : g_pin
            // Tracks the pin even under reset so no false edge follows reset.
            always_ff @(posedge clk) begin
                prev_q[g] <= pins[g];
            end
            assign rise[g] = !rst &&  pins[g] && !prev_q[g];
            assign fall[g] = !rst && !pins[g] &&  prev_q[g];
        end
    endgenerate
endmodule

// File: rtl/chain_mode_latch.sv
module chain_mode_latch
    import chain_adc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  logic      sdi,
    input  logic      sclk,
    output port_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (capture) begin
            cfg.chain <= !sdi;
            cfg.busy  <= sclk;
        end
    end
endmodule

// File: rtl/chain_shifter.sv
module chain_shifter
    import chain_adc_pkg::*;
#(
    parameter int DATA_W  = WORD_W,
    parameter bit IS_HEAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              shift_edge,
    input  logic              sdi,
    input  port_cfg_t         cfg,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output phase_t            phase,
    output logic [DATA_W-1:0] data,
    output logic              busy_bit,
    output logic              pend,
    output logic              out_bit
);
    localparam int MSB = DATA_W - 1;

    logic up_ok;

    generate
        if (IS_HEAD) begin : g_head
            assign up_ok = 1'b1;
        end else begin : g_link
            assign up_ok = sdi;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            data     <= '0;
            busy_bit <= 1'b0;
            pend     <= 1'b0;
        end else if (start) begin
            phase    <= PH_CONV;
            data     <= '0;
            busy_bit <= 1'b0;
            pend     <= 1'b0;
        end else begin
            unique case (phase)
                PH_CONV: begin
                    if (conv_done) begin
                        phase    <= PH_READY;
                        data     <= conv_data;
                        pend     <= cfg.busy;
                        busy_bit <= cfg.busy && up_ok;
                    end
                end
                PH_READY: begin
                    if (shift_edge && cfg.chain) begin
                        if (pend) begin
                            pend     <= 1'b0;
                            busy_bit <= 1'b0;
                        end else begin
                            data <= {data[MSB-1:0], sdi};
                        end
                    end else if (pend && up_ok) begin
                        busy_bit <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign out_bit = pick_out(pend, busy_bit, data[MSB]);
endmodule

// File: rtl/chain_adc_port.sv
module chain_adc_port
    import chain_adc_pkg::*;
#(
    parameter int DATA_W  = WORD_W,
    parameter bit IS_HEAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnvst,
    input  logic              sdi,
    input  logic              sclk,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int PIN_CNV = 0;
    localparam int PIN_CLK = 1;

    logic [1:0]        pin_rise;
    logic [1:0]        pin_fall;
    port_cfg_t         cfg_q;
    phase_t            phase_q;
    logic [DATA_W-1:0] data_q;
    logic              busy_q;
    logic              pend_q;
    logic              out_bit;
    logic              force_low;

    chain_edge_sense #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .pins ({sclk, cnvst}),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    chain_mode_latch u_mode (
        .clk     (clk),
        .rst     (rst),
        .capture (pin_rise[PIN_CNV]),
        .sdi     (sdi),
        .sclk    (sclk),
        .cfg     (cfg_q)
    );

    chain_shifter #(.DATA_W(DATA_W), .IS_HEAD(IS_HEAD)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .start      (pin_rise[PIN_CNV]),
        .shift_edge (pin_fall[PIN_CLK]),
        .sdi        (sdi),
        .cfg        (cfg_q),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .phase      (phase_q),
        .data       (data_q),
        .busy_bit   (busy_q),
        .pend       (pend_q),
        .out_bit    (out_bit)
    );

    // Both pins low pull the output low so the next device joins the chain.
    assign force_low = !cnvst && !sdi;
    assign sdo_en    = cfg_q.chain || force_low;
    assign sdo       = !force_low && cfg_q.chain && out_bit;
endmodule

// File: rtl/chain_adc_port_chk.sv
module chain_adc_port_chk
    import chain_adc_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter bit HEAD   = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              cnvst,
    input logic              sdi,
    input logic              sclk,
    input logic              conv_done,
    input logic              sdo,
    input logic              sdo_en,
    input logic              cfg_busy,
    input logic              cfg_chain,
    input phase_t            phase,
    input logic [DATA_W-1:0] shift_data,
    input logic              busy_flag,
    input logic              pend
);
    // R3
    force_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnvst && !sdi) |-> (sdo_en && !sdo));

    // R1
    chain_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cnvst) && !sdi) |=> sdo_en);

    // R1
    plain_sel_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cnvst) && sdi) |=> (!sdo_en || !cnvst));

    // R2
    busy_opt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cnvst) |=> (cfg_busy == $past(sclk)));

    // R7
    busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_flag) |-> (HEAD || $past(sdi)));

    // R9
    conv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CONV && !conv_done && !$rose(cnvst)) |=> ($stable(shift_data) && phase == PH_CONV));

    // R8
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && pend && cfg_chain && !sclk && $past(sclk) && !$rose(cnvst))
        |=> ($stable(shift_data) && !pend));

    // R10
    reset_out_chk: assert property (@(posedge clk)
        rst |=> !sdo);
endmodule

bind chain_adc_port chain_adc_port_chk #(.DATA_W(DATA_W), .HEAD(IS_HEAD)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cnvst      (cnvst),
    .sdi        (sdi),
    .sclk       (sclk),
    .conv_done  (conv_done),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .cfg_busy   (cfg_q.busy),
    .cfg_chain  (cfg_q.chain),
    .phase      (phase_q),
    .shift_data (data_q),
    .busy_flag  (busy_q),
    .pend       (pend_q)
);

// File: tb/chain_adc_port_test.sv
module chain_adc_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnvst = 1'b1;
    logic        sclk = 1'b0;
    logic        head_sdi = 1'b1;
    logic        head_done = 1'b0;
    logic        uut_done = 1'b0;
    logic [15:0] head_word = '0;
    logic [15:0] uut_word = '0;
    logic        link;
    logic        head_en;
    logic        uut_sdo;
    logic        uut_en;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = !clk;

    chain_adc_port #(.DATA_W(16), .IS_HEAD(1'b1)) u_head (
        .clk(clk), .rst(rst), .cnvst(cnvst), .sdi(head_sdi), .sclk(sclk),
        .conv_done(head_done), .conv_data(head_word), .sdo(link), .sdo_en(head_en)
    );

    chain_adc_port #(.DATA_W(16), .IS_HEAD(1'b0)) uut (
        .clk(clk), .rst(rst), .cnvst(cnvst), .sdi(link), .sclk(sclk),
        .conv_done(uut_done), .conv_data(uut_word), .sdo(uut_sdo), .sdo_en(uut_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Expected downstream serial bit after k falls (head word a, own word b).
    function automatic logic exp_bit(input bit busy, input logic [15:0] a, input logic [15:0] b, input int k);
        int j;
        if (busy) begin
            if (k == 0) return 1'b1;
            j = k - 1;
        end else begin
            j = k;
        end
        return (j < 16) ? b[15-j] : a[31-j];
    endfunction

    task automatic pulse(input bit h, input bit u, input bit drop_clk);
        head_done = h;
        uut_done  = u;
        if (drop_clk) sclk = 1'b0;
        step();
        head_done = 1'b0;
        uut_done  = 1'b0;
    endtask

    task automatic run_round(input bit busy, input logic [15:0] a, input logic [15:0] b,
                             input int order, input bit coinc);
        int nbits;
        cnvst = 1'b0; head_sdi = 1'b0; sclk = busy;
        step();
        check("R3 forced low", {uut_sdo, uut_en, link}, {1'b0, 1'b1, 1'b0});
        cnvst = 1'b1;
        step();
        check("R1 chain selected", uut_en, 1'b1);
        check("R4 low during conversion", uut_sdo, 1'b0);
        sclk = 1'b1;
        step();
        if (!coinc) begin
            sclk = 1'b0;   // fall while converting: must be ignored
            step();
        end
        head_word = a; uut_word = b;
        case (order)
            0: begin
                pulse(1'b1, 1'b0, coinc);
                if (busy) check("R7 head busy", link, 1'b1);
                else      check("R5 head msb", link, a[15]);
                pulse(1'b0, 1'b1, 1'b0);
                if (busy) check("R7 busy same cycle as load", uut_sdo, 1'b1);
                else      check("R5 msb", uut_sdo, b[15]);
            end
            1: begin
                pulse(1'b0, 1'b1, coinc);
                if (busy) check("R7 busy gated by upstream", uut_sdo, 1'b0);
                else      check("R5 msb", uut_sdo, b[15]);
                pulse(1'b1, 1'b0, 1'b0);
                if (busy) begin
                    check("R7 head busy", link, 1'b1);
                    check("R7 one cycle lag", uut_sdo, 1'b0);
                    step();
                    check("R7 busy after upstream", uut_sdo, 1'b1);
                end
            end
            default: begin
                pulse(1'b1, 1'b1, coinc);
                if (busy) begin
                    check("R7 simultaneous lag", uut_sdo, 1'b0);
                    step();
                    check("R7 simultaneous busy", uut_sdo, 1'b1);
                end else begin
                    check("R5 msb", uut_sdo, b[15]);
                end
            end
        endcase
        sclk = 1'b0;
        step();
        nbits = busy ? 33 : 32;
        for (int k = 0; k < nbits; k++) begin
            if (busy && k == 0) check("R2 busy bit leads", uut_sdo, 1'b1);
            else if (busy)      check("R8 busy stream", uut_sdo, exp_bit(busy, a, b, k));
            else                check("R6 plain stream", uut_sdo, exp_bit(busy, a, b, k));
            sclk = 1'b1; step();
            sclk = 1'b0; step();
        end
        if (busy) begin
            sclk = 1'b1; step();
            sclk = 1'b0; step();
        end
        check("R6 chain drained", uut_sdo, 1'b0);
        uut_word = ~b | 16'h8000;
        pulse(1'b0, 1'b1, 1'b0);
        check("R9 stray done ignored", uut_sdo, 1'b0);
    endtask

    initial begin
        void'($urandom(32'h5EED_0C11));
        repeat (3) step();
        check("R10 reset sdo", uut_sdo, 1'b0);
        rst = 1'b0;
        step();
        check("R10 after reset", {uut_sdo, uut_en, link, head_en}, 4'b0000);

        // Head port outside chain mode
        cnvst = 1'b0; head_sdi = 1'b1;
        step();
        cnvst = 1'b1;
        step();
        check("R1 plain mode disabled", head_en, 1'b0);
        head_word = 16'hFFFF;
        pulse(1'b1, 1'b0, 1'b0);
        check("R1 plain mode output", {head_en, link}, 2'b00);

        // Directed corners
        run_round(1'b0, 16'h8001, 16'h7FFE, 0, 1'b0);
        run_round(1'b1, 16'h1234, 16'h0F0F, 1, 1'b0);
        run_round(1'b1, 16'hFFFF, 16'h0000, 2, 1'b1);
        run_round(1'b0, 16'hA5A5, 16'h5A5A, 2, 1'b1);

        // Random rounds
        for (int r = 0; r < 16; r++) begin
            run_round(1'($urandom()), 16'($urandom()), 16'($urandom()),
                      int'($urandom_range(0, 2)), 1'($urandom()));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule